// File: doc/BRIEF.md
# System Fault Signalling Controller

This block belongs to a system event controller. It watches an external fault line, which it brings into the clock domain through a two-stage synchroniser. When input sampling is enabled, it records the fault in a sticky status register. It then reports the fault on the chip's fault pins in one of two styles:

- **Heartbeat style:** a pin toggles at a programmable rate while the system is healthy and freezes as soon as a fault is recorded.
- **Level style:** a fault pin is paired with its complement.

When a fault first becomes active, the block can also emit a one-cycle system reset request and a one-cycle trigger pulse.

Software reaches the block through a small register port with three word addresses: control, status and heartbeat divider. Status bits are cleared by writing ones to them. A self-clearing bit in the control word returns every register to its reset value.

Recording is handled by a three-state machine:

| State | Meaning |
|---|---|
| `ST_CLEAR` | No fault recorded. |
| `ST_RAISE` | First cycle of a new fault; the pulses fire here. |
| `ST_HELD` | Fault is recorded and waiting to be cleared. |

The named transitions are:

| Transition | From → To | Condition |
|---|---|---|
| *detect* | `ST_CLEAR` → `ST_RAISE` | A synchronised and enabled fault is seen. |
| *settle* | `ST_RAISE` → `ST_HELD` | Always taken after one cycle. |
| *acknowledge* | `ST_RAISE` or `ST_HELD` → `ST_CLEAR` | Software clears the active bit and no enabled fault is present in that cycle. |
| *purge* | any state → `ST_CLEAR` | Soft reset. |

Top module: `fault_signal_ctrl`

## Requirements
- R1: After rst_n is released:
  - control, status and divider all read 0;
  - fault_out=0, fault_n_out=1, hb_out=0, rst_req=0 and trig_out=0.
- R2: Address map and readback:
  - Control is at address 0. Its fields are: mode bit 12 (0 = level, 1 = heartbeat), input enable bit 7, reset-request enable bit 6, trigger enable bit 5, pin enable bit 4 and soft reset bit 1.
  - Status is at address 1 and the divider is at address 2.
  - A control write reads back masked with 0x10F0.
- R3: With mode=1 and pin enable=1, and no fault active, hb_out toggles once every DIV+1 clock cycles, where DIV is the divider value. While a fault is active, hb_out holds its level.
- R4: fault_in passes through two flops. When the input enable is set, a fault present at the input sets status bit 0 (active) and bit 1 (external source) on the third rising edge after fault_in rises. When the input enable is clear, fault_in has no effect on status.
- R5: With the reset-request enable set, rst_req is high for exactly the one cycle in which status bit 0 first becomes 1. With that enable clear, no rst_req pulse occurs.
- R6: With the trigger enable set, trig_out is high for exactly that same first cycle of the fault.
- R7: With mode=0 and pin enable=1, fault_out equals status bit 0 and fault_n_out is its inverse. In heartbeat mode the level pins rest at fault_out=0 and fault_n_out=1.
- R8: With pin enable=0, the pins rest at fault_out=0, fault_n_out=1 and hb_out=0, whatever the fault state.
- R9: Status bits are sticky and are cleared by writing 1 to the bit. A clear of bit 0 has no effect while an enabled synchronised fault is present. Clearing bit 0 leaves bit 1 unchanged.
- R10: A control write with bit 1 set returns control, divider and status to 0. Bit 1 itself always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| fault_in | input | 1 | Asynchronous external fault indication, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational from bus_addr) |
| hb_out | output | 1 | Heartbeat pin; toggles while healthy |
| fault_out | output | 1 | Level fault pin, high on fault |
| fault_n_out | output | 1 | Complementary fault pin, low on fault |
| rst_req | output | 1 | One-cycle system reset request |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
The bench measures the exact three-edge latency from fault_in to the status bits and the pulses. A synchroniser with the wrong depth shows up as a status change one cycle early or late. Pulses that are generated from the level rather than from the edge show up as rst_req or trig_out lasting more than one cycle.

The bench also targets the following corner cases:

- **Clear during a fault:** a write-one-to-clear issued while the fault is still present must not lose the fault. A design with clear taking priority would drop status bit 0 and re-raise duplicate pulses.
- **Heartbeat period:** the period is measured for random divider values. An off-by-one divider shows up as a DIV or DIV+2 interval.
- **Frozen heartbeat:** the pin must stay frozen throughout a fault.
- **Pin gating:** with the pin enable cleared, all pins must rest in the healthy state.
- **Soft reset:** every register, including the divider, must return to zero.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;

    // control word bit positions
    localparam int B_MODE = 12;
    localparam int B_FIEN = 7;
    localparam int B_SREN = 6;
    localparam int B_TOEN = 5;
    localparam int B_FOEN = 4;
    localparam int B_SRST = 1;

    // status word bit positions
    localparam int S_LIVE = 0;
    localparam int S_EXT  = 1;

    typedef struct packed {
        logic mode;   // 1: heartbeat pin, 0: level pins
        logic fien;   // sample external fault
        logic sren;   // reset request on new fault
        logic toen;   // trigger on new fault
        logic foen;   // drive fault pins
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_RAISE = 2'd1,
        ST_HELD  = 2'd2
    } state_t;
endpackage

// File: rtl/fsc_sync.sv
module fsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/fsc_regs.sv
module fsc_regs
    import fsc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output ctrl_t             ctl,
    output logic [DIV_W-1:0]  div,
    output logic              soft_clr
);
    logic wr_ctrl;
    logic wr_div;
    logic unused_wdata;

    assign wr_ctrl      = bus_we && (bus_addr == A_CTRL);
    assign wr_div       = bus_we && (bus_addr == A_DIV);
    assign soft_clr     = wr_ctrl && bus_wdata[B_SRST];
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ctl <= '0;
            div <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl.mode <= bus_wdata[B_MODE];
                ctl.fien <= bus_wdata[B_FIEN];
                ctl.sren <= bus_wdata[B_SREN];
                ctl.toen <= bus_wdata[B_TOEN];
                ctl.foen <= bus_wdata[B_FOEN];
            end
            if (wr_div) begin
                div <= bus_wdata[DIV_W-1:0];
            end
        end
    end
endmodule

// File: rtl/fsc_heartbeat.sv
module fsc_heartbeat #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             hb
);
    logic [DIV_W-1:0] cnt;
    logic             hb_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
            cnt  <= '0;
            hb_q <= 1'b0;
        end else if (!hold) begin
            if (cnt >= div) begin
                cnt  <= '0;
                hb_q <= ~hb_q;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign hb = hb_q & run;
endmodule

// File: rtl/fault_signal_ctrl.sv
module fault_signal_ctrl
    import fsc_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              hb_out,
    output logic              fault_out,
    output logic              fault_n_out,
    output logic              rst_req,
    output logic              trig_out
);
    ctrl_t            ctl;
    logic [DIV_W-1:0] div;
    logic             soft_clr;
    logic             fault_sync;
    logic             set_cond;
    logic             clr_live;
    logic             clr_ext;
    logic             ext_q;
    logic             active;
    state_t           state;
    state_t           nxt;

    fsc_regs #(.DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .ctl      (ctl),
        .div      (div),
        .soft_clr (soft_clr)
    );

    fsc_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (soft_clr),
        .d    (fault_in),
        .q    (fault_sync)
    );

    fsc_heartbeat #(.DIV_W(DIV_W)) u_hb (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (soft_clr),
        .run  (ctl.mode & ctl.foen),
        .hold (active),
        .div  (div),
        .hb   (hb_out)
    );

    assign set_cond = fault_sync & ctl.fien;
    assign clr_live = bus_we && (bus_addr == A_STAT) && bus_wdata[S_LIVE];
    assign clr_ext  = bus_we && (bus_addr == A_STAT) && bus_wdata[S_EXT];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            state <= ST_CLEAR;
        end else begin
            state <= nxt;
        end
    end

    // transitions: detect, settle, acknowledge
    always_comb begin
        nxt = state;
        unique case (state)
            ST_CLEAR: nxt = set_cond ? ST_RAISE : ST_CLEAR;
            ST_RAISE: nxt = (clr_live && !set_cond) ? ST_CLEAR : ST_HELD;
            ST_HELD:  nxt = (clr_live && !set_cond) ? ST_CLEAR : ST_HELD;
            default:  nxt = ST_CLEAR;
        endcase
    end

    // external-source status bit, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ext_q <= 1'b0;
        end else if (set_cond) begin
            ext_q <= 1'b1;
        end else if (clr_ext) begin
            ext_q <= 1'b0;
        end
    end

    // outputs from state
    always_comb begin
        active      = (state != ST_CLEAR);
        rst_req     = (state == ST_RAISE) && ctl.sren;
        trig_out    = (state == ST_RAISE) && ctl.toen;
        fault_out   = active && ctl.foen && !ctl.mode;
        fault_n_out = !fault_out;
    end

    // register read
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_MODE] = ctl.mode;
                bus_rdata[B_FIEN] = ctl.fien;
                bus_rdata[B_SREN] = ctl.sren;
                bus_rdata[B_TOEN] = ctl.toen;
                bus_rdata[B_FOEN] = ctl.foen;
            end
            A_STAT: begin
                bus_rdata[S_LIVE] = active;
                bus_rdata[S_EXT]  = ext_q;
            end
            A_DIV:   bus_rdata[DIV_W-1:0] = div;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
    import fsc_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   rst_req,
    input logic   trig_out,
    input logic   hb_out,
    input logic   fault_out,
    input logic   fault_n_out,
    input logic   active,
    input ctrl_t  ctl,
    input state_t state
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R5

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out); // R6

    AST_HB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && ctl.mode && ctl.foen
         && $past(ctl.mode) && $past(ctl.foen)) |-> $stable(hb_out)); // R3

    AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.foen |-> (!fault_out && fault_n_out && !hb_out)); // R8

    AST_RAISE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAISE) |-> $past(ctl.fien)); // R4
endmodule

bind fault_signal_ctrl fsc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (rst_req),
    .trig_out   (trig_out),
    .hb_out     (hb_out),
    .fault_out  (fault_out),
    .fault_n_out(fault_n_out),
    .active     (active),
    .ctl        (ctl),
    .state      (state)
);

// File: tb/fault_signal_ctrl_test.sv
`timescale 1ns/1ps
module fault_signal_ctrl_test;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DIV  = 2'd2;
    localparam logic [15:0] C_MODE = 16'h1000;
    localparam logic [15:0] C_FIEN = 16'h0080;
    localparam logic [15:0] C_SREN = 16'h0040;
    localparam logic [15:0] C_TOEN = 16'h0020;
    localparam logic [15:0] C_FOEN = 16'h0010;
    localparam logic [15:0] C_SRST = 16'h0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_in = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        hb_out, fault_out, fault_n_out, rst_req, trig_out;

    int vectors = 0;
    int miscompares = 0;
    int req_pulses = 0;

    always #2.5 clk = ~clk;

    fault_signal_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .hb_out(hb_out), .fault_out(fault_out),
        .fault_n_out(fault_n_out), .rst_req(rst_req), .trig_out(trig_out)
    );

    always @(negedge clk) if (rst_n && rst_req) req_pulses++;

    function automatic logic [15:0] exp_ctrl(logic [15:0] w);
        return w[1] ? 16'h0000 : (w & 16'h10F0);
    endfunction

    function automatic logic exp_level(logic [15:0] c, logic act);
        return (c & C_FOEN) != 0 && (c & C_MODE) == 0 && act;
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 16'd0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic hb_period(int d);
        logic prev;
        int n;
        wr(A_DIV, 16'(d));
        wr(A_CTRL, C_MODE | C_FOEN);
        prev = hb_out;
        for (int k = 0; k < 40 && hb_out == prev; k++) @(negedge clk);
        prev = hb_out;
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            n++;
            if (hb_out != prev) break;
        end
        check("R3 heartbeat interval", n, d + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] w;
        logic        prev;
        int          base;
        int          moved;
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_F17);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_CTRL, d); check("R1 ctrl", d, 0);
        rd(A_STAT, d); check("R1 status", d, 0);
        rd(A_DIV, d);  check("R1 divider", d, 0);
        check("R1 fault_out", fault_out, 0);
        check("R1 fault_n_out", fault_n_out, 1);
        check("R1 hb_out", hb_out, 0);
        check("R1 rst_req", rst_req, 0);

        // R4 input ignored with enable clear
        wr(A_CTRL, C_SREN | C_TOEN | C_FOEN);
        fault_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(A_STAT, d); check("R4 disabled input status", d, 0);
        check("R5 no pulse when disabled input", req_pulses, 0);
        fault_in = 1'b0;
        repeat (3) @(negedge clk);

        // R4/R5/R6/R7 latency and pulses in level mode
        wr(A_CTRL, C_FIEN | C_SREN | C_TOEN | C_FOEN);
        fault_in = 1'b1;
        @(negedge clk); rd(A_STAT, d); check("R4 status after edge 1", d, 0);
        @(negedge clk); rd(A_STAT, d); check("R4 status after edge 2", d, 0);
        @(negedge clk); rd(A_STAT, d); check("R4 status after edge 3", d, 3);
        check("R5 rst_req first cycle", rst_req, 1);
        check("R6 trig_out first cycle", trig_out, 1);
        check("R7 fault_out on fault", fault_out, 1);
        check("R7 fault_n_out on fault", fault_n_out, 0);
        @(negedge clk);
        check("R5 rst_req second cycle", rst_req, 0);
        check("R6 trig_out second cycle", trig_out, 0);

        // R9 clear ignored while fault present; bits cleared separately
        wr(A_STAT, 16'h0001);
        rd(A_STAT, d); check("R9 clear blocked by live fault", d, 3);
        check("R5 single pulse per fault", req_pulses, 1);
        fault_in = 1'b0;
        repeat (3) @(negedge clk);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, d); check("R9 active cleared ext kept", d, 2);
        check("R7 fault_out after clear", fault_out, 0);
        check("R7 fault_n_out after clear", fault_n_out, 1);
        wr(A_STAT, 16'h0002);
        rd(A_STAT, d); check("R9 ext cleared", d, 0);

        // R8 pins quiet with pin enable clear, R5 no pulse without enable
        wr(A_CTRL, C_FIEN);
        base = req_pulses;
        fault_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(A_STAT, d); check("R8 fault recorded", d, 3);
        check("R8 fault_out quiet", fault_out, 0);
        check("R8 fault_n_out quiet", fault_n_out, 1);
        check("R8 hb_out quiet", hb_out, 0);
        check("R5 no pulse with enable clear", req_pulses, base);

        // R10 soft reset
        wr(A_DIV, 16'h0005);
        wr(A_CTRL, C_FIEN | C_MODE | C_FOEN | C_SRST);
        rd(A_CTRL, d); check("R10 ctrl cleared", d, 0);
        rd(A_STAT, d); check("R10 status cleared", d, 0);
        rd(A_DIV, d);  check("R10 divider cleared", d, 0);
        fault_in = 1'b0;
        repeat (3) @(negedge clk);

        // R3 heartbeat interval for random divider values
        for (int i = 0; i < 6; i++) hb_period($urandom_range(0, 7));
        hb_period(0);

        // R3 freeze during fault, R7 level pins rest in heartbeat mode
        wr(A_DIV, 16'h0001);
        wr(A_CTRL, C_MODE | C_FOEN | C_FIEN);
        fault_in = 1'b1;
        repeat (4) @(negedge clk);
        prev = hb_out;
        moved = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (hb_out != prev) moved++;
        end
        check("R3 heartbeat frozen on fault", moved, 0);
        check("R7 fault_out rests in heartbeat mode", fault_out, 0);
        check("R7 fault_n_out rests in heartbeat mode", fault_n_out, 1);
        fault_in = 1'b0;
        repeat (3) @(negedge clk);
        wr(A_STAT, 16'h0003);
        prev = hb_out;
        moved = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (hb_out != prev) moved++;
            prev = hb_out;
        end
        check("R3 heartbeat resumes", moved > 0, 1);
        wr(A_CTRL, C_MODE);
        moved = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (hb_out) moved++;
        end
        check("R8 heartbeat low without pin enable", moved, 0);

        // R2 random control words
        for (int i = 0; i < 30; i++) begin
            w = 16'($urandom);
            if (i < 3) w = (i == 0) ? 16'hFFFD : (i == 1) ? 16'hFFFF : 16'h10F0;
            wr(A_CTRL, w);
            rd(A_CTRL, d); check("R2 ctrl readback", d, exp_ctrl(w));
            check("R7 idle fault_out", fault_out, exp_level(d, 1'b0));
            check("R7 idle fault_n_out", fault_n_out, !exp_level(d, 1'b0));
        end
        wr(A_DIV, 16'h00A5);
        rd(A_DIV, d); check("R2 divider readback", d, 16'h00A5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule